// File: doc/BRIEF.md
# Partitioned Low-Activity 16-bit ALU

This block is a 16-bit arithmetic and logic unit divided into four sub-units. Two are arithmetic and two are logical, and each owns its own operand registers. A 4-bit opcode selects one of sixteen operations. The upper two opcode bits are decoded into a one-hot enable that lets only one sub-unit load new operands on a given clock edge. The other three hold their registers, so they do no switching. The same two bits, registered alongside the operands, steer an output multiplexer. That multiplexer feeds the registered result and carry.

The block is used as the compute stage of a datapath. Operands, carry-in and opcode are presented before one clock edge. The sub-unit captures them on that edge, and the output register shows the answer after the next edge. Because every stage is clocked each cycle, a new operation can be issued every cycle, even when consecutive operations use the same sub-unit.

Top module: `gated_alu16`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `result` and `carry` to zero at that edge, whatever the opcode. The first result after reset is released is also zero.
- R2: Inputs present before clock edge k produce their `result` and `carry` after edge k+1. Only the sub-unit named by `opcode[3:2]` loads operands on an edge, and idle sub-units keep their state.
- R3: Codes 0000 (add) and 0001 (subtract) give `opa+opb` and `opa-opb` modulo 2^16. `carry` is the carry-out for add, and for subtract it is the borrow (1 when `opa < opb`).
- R4: Codes 0010 (increment `opa`) and 0011 (decrement `opa`) wrap modulo 2^16 and give `carry` = 0.
- R5: Code 0100 gives the low 16 bits of `opa*opb` with `carry` = 0. Code 0101 gives `opa+opb+cin`, with `carry` set to the carry-out.
- R6: Code 0110 gives all zeros and code 0111 gives all ones, both with `carry` = 0.
- R7: Codes 1000 to 1011 give `~opa`, `opa&opb`, `opa|opb` and `opa^opb`, with `carry` = 0.
- R8: Codes 1100 to 1111 move `opa` by one bit: shift left and shift right fill the vacated bit with zero, and rotate left and rotate right wrap the bit that leaves. All give `carry` = 0.
- R9: A different opcode may be issued on every cycle, and every operation's result appears in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry-in for add-with-carry |
| opcode | input | 4 | Operation select; [3:2] picks the sub-unit, [1:0] the operation |
| result | output | 16 | Registered result |
| carry | output | 1 | Registered carry or borrow out |

## Verification
The bench builds the block with its default width of 16 and four sub-units. With these values, the operand patterns reach every wrap point directly: all-ones plus one, zero minus one, and a product that overflows to zero. The 16-bit vectors also expose the edge bits that shifts and rotates move, and a back-to-back stream covers both a change of sub-unit and repeated use of the same sub-unit on consecutive cycles.

// File: rtl/gated_alu16_pkg.sv
package gated_alu16_pkg;
    localparam int DATA_W   = 16;
    localparam int CODE_W   = 4;
    localparam int SEL_W    = 2;
    localparam int SUB_W    = CODE_W - SEL_W;
    localparam int NUM_UNIT = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        UNIT_ARITH_A = 2'd0,
        UNIT_ARITH_B = 2'd1,
        UNIT_LOGIC_A = 2'd2,
        UNIT_LOGIC_B = 2'd3
    } unit_kind_e;
endpackage

// File: rtl/alu_unit_dec.sv
module alu_unit_dec #(
    parameter int SEL_W = 2,
    localparam int NUM  = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NUM-1:0]   en_onehot
);
    always_comb begin
        en_onehot = '0;
        en_onehot[sel] = 1'b1;
    end
endmodule

// File: rtl/alu_subunit.sv
module alu_subunit
    import gated_alu16_pkg::*;
#(
    parameter int         W     = 16,
    parameter int         SW    = 2,
    parameter unit_kind_e KIND  = UNIT_ARITH_A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic          c_in,
    input  logic [SW-1:0] sub_in,
    output logic [W-1:0]  res,
    output logic          co
);
    logic [W-1:0]  a_q, b_q;
    logic          c_q;
    logic [SW-1:0] sub_q;

    // Enable-model of a low-transparent latch clock gate: the unit's
    // registers update only on edges where its decoded enable is set.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= 1'b0;
            sub_q <= '0;
        end else if (load_en) begin
            a_q   <= a_in;
            b_q   <= b_in;
            c_q   <= c_in;
            sub_q <= sub_in;
        end
    end

    generate
        if (KIND == UNIT_ARITH_A) begin : g_arith_a
            always_comb begin
                res = '0;
                co  = 1'b0;
                unique case (sub_q)
                    2'd0: {co, res} = {1'b0, a_q} + {1'b0, b_q};
                    2'd1: begin
                        res = a_q - b_q;
                        co  = (a_q < b_q);
                    end
                    2'd2: res = a_q + {{(W-1){1'b0}}, 1'b1};
                    default: res = a_q - {{(W-1){1'b0}}, 1'b1};
                endcase
            end
        end else if (KIND == UNIT_ARITH_B) begin : g_arith_b
            logic [W-1:0] prod_lo;
            assign prod_lo = a_q * b_q;
            always_comb begin
                res = '0;
                co  = 1'b0;
                unique case (sub_q)
                    2'd0: res = prod_lo;
                    2'd1: {co, res} = {1'b0, a_q} + {1'b0, b_q} + {{W{1'b0}}, c_q};
                    2'd2: res = '0;
                    default: res = '1;
                endcase
            end
        end else if (KIND == UNIT_LOGIC_A) begin : g_logic_a
            assign co = 1'b0;
            always_comb begin
                unique case (sub_q)
                    2'd0: res = ~a_q;
                    2'd1: res = a_q & b_q;
                    2'd2: res = a_q | b_q;
                    default: res = a_q ^ b_q;
                endcase
            end
        end else begin : g_logic_b
            assign co = 1'b0;
            always_comb begin
                unique case (sub_q)
                    2'd0: res = {a_q[W-2:0], 1'b0};
                    2'd1: res = {1'b0, a_q[W-1:1]};
                    2'd2: res = {a_q[W-2:0], a_q[W-1]};
                    default: res = {a_q[0], a_q[W-1:1]};
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gated_alu16.sv
module gated_alu16
    import gated_alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    input  logic [CODE_W-1:0] opcode,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    logic [NUM_UNIT-1:0]             unit_en;
    logic [NUM_UNIT-1:0][DATA_W-1:0] unit_res;
    logic [NUM_UNIT-1:0]             unit_co;
    logic [SEL_W-1:0]                sel_q;

    alu_unit_dec #(.SEL_W(SEL_W)) u_dec (
        .sel       (opcode[CODE_W-1 -: SEL_W]),
        .en_onehot (unit_en)
    );

    for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
        alu_subunit #(
            .W    (DATA_W),
            .SW   (SUB_W),
            .KIND (unit_kind_e'(u))
        ) u_sub (
            .clk     (clk),
            .rst     (rst),
            .load_en (unit_en[u]),
            .a_in    (opa),
            .b_in    (opb),
            .c_in    (cin),
            .sub_in  (opcode[SUB_W-1:0]),
            .res     (unit_res[u]),
            .co      (unit_co[u])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            result <= '0;
            carry  <= 1'b0;
        end else begin
            sel_q  <= opcode[CODE_W-1 -: SEL_W];
            result <= unit_res[sel_q];
            carry  <= unit_co[sel_q];
        end
    end
endmodule

// File: rtl/gated_alu16_chk.sv
module gated_alu16_chk
    import gated_alu16_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic [CODE_W-1:0]               opcode,
    input logic [NUM_UNIT-1:0]             unit_en,
    input logic [NUM_UNIT-1:0][DATA_W-1:0] unit_res,
    input logic [DATA_W-1:0]               result,
    input logic                            carry
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (result == '0 && !carry));

    assert_one_unit_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot(unit_en));

    for (genvar u = 0; u < NUM_UNIT; u++) begin : g_hold
        assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
            !unit_en[u] |=> $stable(unit_res[u]));
    end

    assert_clear_op_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(opcode, 2) == 4'b0110)
            |-> (result == '0 && !carry));

    assert_logic_no_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(opcode[3], 2)) |-> !carry);
endmodule

bind gated_alu16 gated_alu16_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .unit_en  (unit_en),
    .unit_res (unit_res),
    .result   (result),
    .carry    (carry)
);

// File: tb/gated_alu16_test.sv
module gated_alu16_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0, opb = '0;
    logic        cin = 1'b0;
    logic [3:0]  opcode = '0;
    logic [15:0] result;
    logic        carry;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    gated_alu16 uut (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .cin(cin),
        .opcode(opcode), .result(result), .carry(carry)
    );

    // {opcode, opa, opb, cin, expected result, expected carry}
    localparam int NV = 22;
    localparam logic [53:0] VEC [NV] = '{
        {4'h0, 16'h1234, 16'h1111, 1'b0, 16'h2345, 1'b0},
        {4'h0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
        {4'h1, 16'h0005, 16'h0003, 1'b0, 16'h0002, 1'b0},
        {4'h1, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 1'b1},
        {4'h2, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0},
        {4'h3, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
        {4'h2, 16'h00FF, 16'h0000, 1'b0, 16'h0100, 1'b0},
        {4'h4, 16'h0012, 16'h0034, 1'b0, 16'h03A8, 1'b0},
        {4'h4, 16'h0100, 16'h0100, 1'b0, 16'h0000, 1'b0},
        {4'h5, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
        {4'h5, 16'h1000, 16'h0234, 1'b1, 16'h1235, 1'b0},
        {4'h5, 16'h1000, 16'h0234, 1'b0, 16'h1234, 1'b0},
        {4'h6, 16'hABCD, 16'h1234, 1'b1, 16'h0000, 1'b0},
        {4'h7, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
        {4'h8, 16'h0F0F, 16'h0000, 1'b0, 16'hF0F0, 1'b0},
        {4'h9, 16'hF0F0, 16'hFF00, 1'b0, 16'hF000, 1'b0},
        {4'hA, 16'hF0F0, 16'h0F00, 1'b0, 16'hFFF0, 1'b0},
        {4'hB, 16'hAAAA, 16'hFFFF, 1'b0, 16'h5555, 1'b0},
        {4'hC, 16'h8001, 16'h0000, 1'b0, 16'h0002, 1'b0},
        {4'hD, 16'h8001, 16'h0000, 1'b0, 16'h4000, 1'b0},
        {4'hE, 16'h8001, 16'h0000, 1'b0, 16'h0003, 1'b0},
        {4'hF, 16'h8001, 16'h0000, 1'b0, 16'hC000, 1'b0}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1: return "R3";
            4'h2, 4'h3: return "R4";
            4'h4, 4'h5: return "R5";
            4'h6, 4'h7: return "R6";
            4'h8, 4'h9, 4'hA, 4'hB: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] er, input logic ec);
        n_cmp++;
        if (result !== er || carry !== ec) begin
            n_bad++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     req, result, carry, er, ec);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic c);
        opcode = op; opa = a; opb = b; cin = c;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst = 1'b0;

        // R2 two-edge latency plus operation table (R3..R8)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][53:50], VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check(req_of(VEC[i][53:50]), VEC[i][16:1], VEC[i][0]);
        end

        // R2: result not yet updated after only one edge
        drive(4'h7, 16'h0, 16'h0, 1'b0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        drive(4'h6, 16'h0, 16'h0, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R2", 16'hFFFF, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R2", 16'h0000, 1'b0);

        // R9: a new opcode each cycle, same unit twice then unit changes
        drive(4'h0, 16'h0001, 16'h0002, 1'b0);
        @(posedge clk); @(negedge clk);
        drive(4'h0, 16'hFFFF, 16'h0003, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", 16'h0003, 1'b0);
        drive(4'hB, 16'h00FF, 16'h0F0F, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", 16'h0002, 1'b1);
        drive(4'hE, 16'h4000, 16'h0000, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", 16'h0FF0, 1'b0);
        drive(4'h1, 16'h0000, 16'h0001, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", 16'h8000, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9", 16'hFFFF, 1'b1);

        // R1: reset mid-stream with a live opcode clears at that edge
        drive(4'h7, 16'h0, 16'h0, 1'b0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1", 16'hFFFF, 1'b0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R1", 16'hFFFF, 1'b0);

        finish_run();
    end
endmodule